// File: doc/BRIEF.md
# Bank-Expanded Word Memory

This block is a small read/write word memory whose depth is doubled by tiling identical four-word banks. Each bank holds its words in single-bit storage cells and owns a local word decoder that is enabled only by the bank's chip select. The top level splits the address. The low bits reach every bank unchanged. The remaining high bit drives a one-of-two line decoder whose outputs are the bank chip selects.

Write data is broadcast to every bank. Each bank drives zeros from every word that is not selected for a read. The per-bank outputs are then combined by a plain OR into the single output bus, so no tri-state or multiplexer tree is needed. A small control unit turns the memory enable and the read/write line into read and write strobes for the datapath. Writes are taken on the rising clock edge. Reads are combinational from the present address.

Top module: `bankedWordRam`

## Requirements
- R1: While `memEn` is 0, no word is selected and `dOut` is all zeros, whatever `rdWr` and `addr` are.
- R2: While `memEn` is 0, no stored bit changes, even when `rdWr` is 0 and new data is present on `dIn`.
- R3: `rdWr` = 1 with `memEn` = 1 is a read: in the same cycle `dOut` equals the word stored at `addr`.
- R4: `rdWr` = 0 with `memEn` = 1 is a write: on the next rising `clk` edge, `dIn` is stored into the word at `addr`, and a later read of that address returns it.
- R5: A write changes only the addressed word. The other three words of the same bank and all four words of the other bank keep their contents.
- R6: Address bit 2 picks the bank (0 = first bank, holding addresses 0 to 3; 1 = second bank, holding addresses 4 to 7), and bits 1:0 pick the word inside it. Two addresses that differ only in bit 2 are therefore separate storage locations.
- R7: During a write cycle, `dOut` is all zeros, so stored data never appears on the output while writing.
- R8: A read does not alter memory: repeated reads of the same address return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| memEn | input | 1 | Memory enable, active high |
| rdWr | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Word address; bit 2 selects the bank |
| dIn | input | 4 | Write data, shared by all banks |
| dOut | output | 4 | Read data, OR of all bank outputs |

## Verification
Read results are combinational, so the bench drives address and controls on the falling edge and compares `dOut` one nanosecond later in the same cycle. Writes need one rising edge. Every read check therefore starts at the falling edge after the write's rising edge, which puts it exactly one cycle after the write was presented. The zero output during writes and while disabled is also checked within the cycle of the stimulus, before the clock edge that would commit anything. A reference array updated only on real writes supplies the expected value of every location after each scenario.

// File: rtl/bankedRamPkg.sv
package bankedRamPkg;

  // Strobes handed from the control unit to the datapath.
  typedef struct packed {
    logic enable;  // memory is enabled this cycle
    logic write;   // store dIn into the addressed word on the clock edge
    logic read;    // drive the addressed word onto the output
  } ramStrobeT;

endpackage

// File: rtl/lineDecoder.sv
// Binary-to-one-hot decoder with an enable; all lines low when disabled.
module lineDecoder #(
  parameter int IN_W = 2
) (
  input  logic                 en,
  input  logic [IN_W-1:0]      code,
  output logic [(1<<IN_W)-1:0] lines
);
  localparam int LINES = 1 << IN_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = en && (code == IN_W'(i));
  end
endmodule

// File: rtl/ramCtrl.sv
// Turns the enable and direction inputs into datapath strobes.
module ramCtrl
  import bankedRamPkg::*;
(
  input  logic      memEn,
  input  logic      rdWr,
  output ramStrobeT strobe
);
  always_comb begin
    strobe.enable = memEn;
    strobe.write  = memEn && !rdWr;
    strobe.read   = memEn &&  rdWr;
  end
endmodule

// File: rtl/subRam.sv
// One bank: a word decoder gated by the chip select and an array of cells.
module subRam
  import bankedRamPkg::*;
#(
  parameter int WORD_ADDR_W = 2,
  parameter int DATA_W      = 4
) (
  input  logic                   clk,
  input  logic                   chipSel,
  input  ramStrobeT              strobe,
  input  logic [WORD_ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0]      dIn,
  output logic [DATA_W-1:0]      dOut
);
  localparam int WORDS = 1 << WORD_ADDR_W;

  logic [WORDS-1:0]  wordSel;
  logic [DATA_W-1:0] cells [WORDS];
  logic [DATA_W-1:0] wordOut [WORDS];

  lineDecoder #(.IN_W(WORD_ADDR_W)) u_wordDec (
    .en    (chipSel && strobe.enable),
    .code  (wordAddr),
    .lines (wordSel)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (wordSel[w] && strobe.write) cells[w] <= dIn;
    end
    // Unselected words contribute zeros to the OR tree.
    assign wordOut[w] = (wordSel[w] && strobe.read) ? cells[w] : '0;
  end

  always_comb begin
    dOut = '0;
    for (int w = 0; w < WORDS; w++) dOut = dOut | wordOut[w];
  end
endmodule

// File: rtl/ramDatapath.sv
// Bank array, bank-select decoder and output OR combine.
module ramDatapath
  import bankedRamPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int WORD_ADDR_W = 2,
  parameter int DATA_W      = 4
) (
  input  logic              clk,
  input  ramStrobeT         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  localparam int BANK_SEL_W = ADDR_W - WORD_ADDR_W;
  localparam int NUM_BANKS  = 1 << BANK_SEL_W;

  logic [NUM_BANKS-1:0] chipSel;
  logic [DATA_W-1:0]    bankOut [NUM_BANKS];

  lineDecoder #(.IN_W(BANK_SEL_W)) u_bankDec (
    .en    (strobe.enable),
    .code  (addr[ADDR_W-1:WORD_ADDR_W]),
    .lines (chipSel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    subRam #(.WORD_ADDR_W(WORD_ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .chipSel  (chipSel[b]),
      .strobe   (strobe),
      .wordAddr (addr[WORD_ADDR_W-1:0]),
      .dIn      (dIn),
      .dOut     (bankOut[b])
    );
  end

  always_comb begin
    dOut = '0;
    for (int b = 0; b < NUM_BANKS; b++) dOut = dOut | bankOut[b];
  end
endmodule

// File: rtl/bankedWordRam.sv
// Thin top: control unit plus datapath.
module bankedWordRam
  import bankedRamPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int WORD_ADDR_W = 2,
  parameter int DATA_W      = 4
) (
  input  logic              clk,
  input  logic              memEn,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  ramStrobeT strobe;

  ramCtrl u_ctrl (
    .memEn  (memEn),
    .rdWr   (rdWr),
    .strobe (strobe)
  );

  ramDatapath #(
    .ADDR_W      (ADDR_W),
    .WORD_ADDR_W (WORD_ADDR_W),
    .DATA_W      (DATA_W)
  ) u_dpath (
    .clk    (clk),
    .strobe (strobe),
    .addr   (addr),
    .dIn    (dIn),
    .dOut   (dOut)
  );
endmodule

// File: rtl/bankedWordRamChk.sv
module bankedWordRamChk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              memEn,
  input logic              rdWr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dIn,
  input logic [DATA_W-1:0] dOut
);
  // Checks start once two edges of history exist.
  logic [1:0] edgeCnt = 2'd0;
  logic       armed;
  always_ff @(posedge clk) begin
    if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
  end
  assign armed = (edgeCnt >= 2'd2);

  // R1
  idle_out_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !memEn |-> dOut == '0);

  // R7
  write_out_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    (memEn && !rdWr) |-> dOut == '0);

  // R4
  write_then_read_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(memEn && !rdWr) && memEn && rdWr && addr == $past(addr))
      |-> dOut == $past(dIn));

  // R8
  reread_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(memEn && rdWr) && memEn && rdWr && addr == $past(addr))
      |-> dOut == $past(dOut));

  // R2
  idle_keeps_data_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(memEn && rdWr, 2) && !$past(memEn) && memEn && rdWr
      && addr == $past(addr, 2)) |-> dOut == $past(dOut, 2));
endmodule

bind bankedWordRam bankedWordRamChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .memEn (memEn),
  .rdWr  (rdWr),
  .addr  (addr),
  .dIn   (dIn),
  .dOut  (dOut)
);

// File: tb/tb_bankedWordRam.sv
`timescale 1ns/1ps
module tb_bankedWordRam;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              memEn = 1'b0;
  logic              rdWr = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;

  logic [DATA_W-1:0] refMem [DEPTH];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bankedWordRam dut (
    .clk(clk), .memEn(memEn), .rdWr(rdWr), .addr(addr), .dIn(dIn), .dOut(dOut)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dOut=%h expected=%h (addr=%0d)", req, act, exp, addr);
    end
  endtask

  // Write cycle; output must stay zero during it (R7).
  task automatic writeWord(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    memEn = 1'b1; rdWr = 1'b0; addr = ADDR_W'(a); dIn = d;
    #1 check("R7", dOut, '0);
    refMem[a] = d;
  endtask

  task automatic readWord(input string req, input int a);
    @(negedge clk);
    memEn = 1'b1; rdWr = 1'b1; addr = ADDR_W'(a);
    #1 check(req, dOut, refMem[a]);
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < DEPTH; a++) readWord(req, a);
  endtask

  // Idle state: disabled memory drives zeros for any control pattern (R1).
  task automatic testIdle();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      memEn = 1'b0; rdWr = a[0]; addr = ADDR_W'(a); dIn = 4'hF;
      #1 check("R1", dOut, '0);
    end
  endtask

  // Distinct value in all eight locations; bank bit separates them (R4, R6).
  task automatic testFill();
    for (int a = 0; a < DEPTH; a++) writeWord(a, DATA_W'(a + 3));
    readAll("R6");
    writeWord(2, 4'hA);
    readWord("R4", 2);
    readWord("R3", 6);
  endtask

  // Write in one bank, whole other bank must be unchanged (R5).
  task automatic testCrossBank();
    writeWord(1, 4'h5);
    for (int a = 4; a < 8; a++) readWord("R5", a);
    writeWord(7, 4'hC);
    for (int a = 0; a < 4; a++) readWord("R5", a);
    for (int a = 4; a < 7; a++) readWord("R5", a);
  endtask

  // Disabled writes store nothing (R2).
  task automatic testDisabledWrite();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      memEn = 1'b0; rdWr = 1'b0; addr = ADDR_W'(a); dIn = ~refMem[a];
      #1 check("R1", dOut, '0);
    end
    readAll("R2");
  endtask

  // Back-to-back reads, all-ones and all-zero patterns (R8, R3).
  task automatic testPatterns();
    writeWord(0, 4'hF);
    writeWord(4, 4'h0);
    readWord("R8", 0);
    readWord("R8", 0);
    readWord("R8", 4);
    readWord("R8", 4);
    writeWord(3, 4'h9);
    writeWord(3, 4'h6);
    readWord("R3", 3);
    readAll("R5");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) refMem[a] = '0;
    repeat (3) @(negedge clk);
    testIdle();
    testFill();
    testCrossBank();
    testDisabledWrite();
    testPatterns();
    @(negedge clk);
    memEn = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule